// File: doc/BRIEF.md
# Converter Fault Protection Controller

This block supervises a single-phase step-down converter and turns the digital outputs of its analog comparators into gate override requests for the driver stage. It watches output overvoltage, output undervoltage and two levels of inductor overcurrent. When any of them trips, it latches a fault, holds the high-side switch off, and places the low-side switch and the output bleed path in the state that fault requires. A two-bit code reports which fault was latched first.

Overvoltage is handled in two phases. First the low side is forced on to pull the output down. Once the output has fallen below half of the reference, the low side is released and a bleed resistor drains what is left. Overcurrent has a slow path and a fast path. The slow path needs the lower threshold on a set number of consecutive switching cycles. The fast path trips on the first sample above the upper threshold.

A latched fault is cleared only by dropping enable or by losing supply power. While the supply is up but the converter is disabled, the block runs a pre-enable guard: an overvoltage flag forces the low side on directly, without latching anything.

Top module: `conv_fault_guard`

## Requirements
- R1: After reset, and whenever supply-good is low, every gate override is 0, bleed is 0 and the fault code is 00.
- R2: While enabled with supply good and no fault latched, the overvoltage flag latches an overvoltage fault whether or not soft-start has finished. From the next cycle the code is 01, high side is forced off, low side is forced on and bleed is 0.
- R3: During an overvoltage fault, once the below-half-reference flag is seen, from the next cycle the low-side-on request drops and low-side-off and bleed are asserted, with high side still off. This discharge phase persists even if the flag later drops.
- R4: The undervoltage flag latches an undervoltage fault (code 10, high side off, low side off, bleed 0) only while soft-start-done is high. Before that it has no effect on any output.
- R5: A level-1 overcurrent flag present on OC_CYCLES (default 4) consecutive cycle ticks latches an overcurrent fault (code 11, high side off, low side off) from the cycle after the last tick. Clock cycles without a tick neither advance nor clear the count.
- R6: A cycle tick without the level-1 flag restarts the consecutive count from zero.
- R7: A level-2 overcurrent flag latches an overcurrent fault from the next cycle, with or without a tick.
- R8: Flags arriving together resolve as overvoltage over overcurrent over undervoltage. The first latched code and its gate pattern are kept, whatever flags arrive later.
- R9: A latched fault is kept while enable and supply-good stay high, even after every flag clears. One cycle with enable low or supply-good low returns the code to 00 and all overrides to 0.
- R10: With supply good and enable low, the overvoltage flag forces low side on from the next cycle, with code 00 and no other override. With enable high this pre-enable path is replaced by the normal overvoltage latch, and with supply-good low it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cycle_tick_i | input | 1 | One-clock pulse per switching cycle |
| enable_i | input | 1 | Converter enable; low clears latched faults |
| supply_ok_i | input | 1 | Both supply rails above their lockout thresholds |
| ss_done_i | input | 1 | Soft-start ramp complete |
| ov_hi_i | input | 1 | Output above 125 % of reference |
| out_low_i | input | 1 | Output below 50 % of reference |
| uv_i | input | 1 | Output below undervoltage threshold |
| oc_lvl1_i | input | 1 | Current sense above the lower overcurrent threshold |
| oc_lvl2_i | input | 1 | Current sense above the upper overcurrent threshold |
| hs_off_o | output | 1 | Force high-side gate low |
| ls_on_o | output | 1 | Force low-side gate high |
| ls_off_o | output | 1 | Force low-side gate low |
| bleed_en_o | output | 1 | Connect output bleed resistor |
| fault_code_o | output | 2 | 00 none, 01 overvoltage, 10 undervoltage, 11 overcurrent |

## Verification
Every result appears one clock after the edge that samples its cause. This includes a fault latch, the switch from clamp to bleed, a clear on enable or supply loss, and the pre-enable low-side request. For slow overcurrent, the result appears one clock after the tick that completes the run. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the following edge, so each check sees exactly the register update caused by the inputs just applied. The overcurrent runs hold the level-1 flag across tickless clocks between ticks, so the count is shown to depend on ticks and not on clocks.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_OV_CLAMP = 3'd1,
      ST_OV_BLEED = 3'd2,
      ST_UV       = 3'd3,
      ST_OC       = 3'd4
   } fg_state_e;

   localparam int unsigned CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      FC_NONE = 2'b00,
      FC_OV   = 2'b01,
      FC_UV   = 2'b10,
      FC_OC   = 2'b11
   } fg_code_e;

   function automatic fg_code_e code_of(input fg_state_e s);
      case (s)
         ST_OV_CLAMP, ST_OV_BLEED: code_of = FC_OV;
         ST_UV:                    code_of = FC_UV;
         ST_OC:                    code_of = FC_OC;
         default:                  code_of = FC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/fg_oc_filter.sv
module fg_oc_filter #(
   parameter int unsigned OC_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic tick_i,
   input  logic lvl1_i,
   output logic trip_o
);

   if (OC_CYCLES < 1) begin : g_bad_cycles
      $error("fg_oc_filter: OC_CYCLES must be at least 1");
   end

   if (OC_CYCLES == 1) begin : g_direct
      // A single qualifying tick is enough: no count to keep.
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign trip_o = tick_i & lvl1_i & ~clear_i;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(OC_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(OC_CYCLES - 1);

      logic [CNT_W-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            run_q <= '0;
         end else if (clear_i) begin
            run_q <= '0;
         end else if (tick_i) begin
            if (!lvl1_i || run_q == LAST) begin
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end

      assign trip_o = tick_i & lvl1_i & ~clear_i & (run_q == LAST);

      // R6: a tick without the level-1 flag restarts the run
      a_r6_gap_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (tick_i && !lvl1_i) |=> (run_q == '0));

      // R5: tickless clocks leave the run untouched
      a_r5_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!tick_i && !clear_i) |=> $stable(run_q));

      a_r5_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
         run_q <= LAST);
   end

endmodule

// File: rtl/fg_fault_fsm.sv
module fg_fault_fsm
   import fg_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      active_i,
   input  logic      ov_i,
   input  logic      out_low_i,
   input  logic      uv_i,
   input  logic      ss_done_i,
   input  logic      oc2_i,
   input  logic      oc_trip_i,
   output fg_state_e state_o
);

   fg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!active_i) begin
         state_d = ST_RUN;
      end else begin
         case (state_q)
            ST_RUN: begin
               // priority: overvoltage, then overcurrent, then undervoltage
               if (ov_i)                     state_d = ST_OV_CLAMP;
               else if (oc2_i || oc_trip_i)  state_d = ST_OC;
               else if (uv_i && ss_done_i)   state_d = ST_UV;
            end
            ST_OV_CLAMP: begin
               if (out_low_i) state_d = ST_OV_BLEED;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_RUN;
      else         state_q <= state_d;
   end

   assign state_o = state_q;

   // R2: overvoltage latches even before soft-start ends
   a_r2_ov_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && state_q == ST_RUN && ov_i) |=> (state_q == ST_OV_CLAMP));

   // R7: upper overcurrent level latches at once
   a_r7_oc2_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && state_q == ST_RUN && !ov_i && oc2_i) |=> (state_q == ST_OC));

   // R4: undervoltage ignored before soft-start completes
   a_r4_uv_needs_ss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && state_q == ST_RUN && !ss_done_i && !ov_i && !oc2_i && !oc_trip_i)
         |=> (state_q == ST_RUN));

   // R8, R9: first latched code kept while enabled and powered
   a_r9_code_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && state_q != ST_RUN) |=> (code_of(state_q) == $past(code_of(state_q))));

   // R9: loss of enable or supply clears
   a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> (state_q == ST_RUN));

   // R3: discharge phase is sticky
   a_r3_bleed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && state_q == ST_OV_BLEED) |=> (state_q == ST_OV_BLEED));

endmodule

// File: rtl/fg_gate_map.sv
module fg_gate_map
   import fg_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  fg_state_e             state_i,
   input  logic                  pre_arm_i,
   input  logic                  ov_i,
   output logic                  hs_off_o,
   output logic                  ls_on_o,
   output logic                  ls_off_o,
   output logic                  bleed_en_o,
   output logic [CODE_W-1:0]     code_o
);

   logic pre_clamp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pre_clamp_q <= 1'b0;
      else         pre_clamp_q <= pre_arm_i & ov_i;
   end

   always_comb begin
      hs_off_o   = (state_i != ST_RUN);
      ls_on_o    = (state_i == ST_OV_CLAMP) | pre_clamp_q;
      ls_off_o   = (state_i == ST_OV_BLEED) | (state_i == ST_UV) | (state_i == ST_OC);
      bleed_en_o = (state_i == ST_OV_BLEED);
      code_o     = code_of(state_i);
   end

   // R10: pre-enable guard drives low side on only
   a_r10_pre_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pre_arm_i && ov_i) |=> (ls_on_o && !hs_off_o && code_o == FC_NONE));

   // R3: bleed only with both switches held off
   a_r3_bleed_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bleed_en_o |-> (hs_off_o && ls_off_o && !ls_on_o));

   a_r1_ls_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ls_on_o && ls_off_o));

endmodule

// File: rtl/conv_fault_guard.sv
module conv_fault_guard #(
   parameter int unsigned OC_CYCLES = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cycle_tick_i,
   input  logic       enable_i,
   input  logic       supply_ok_i,
   input  logic       ss_done_i,
   input  logic       ov_hi_i,
   input  logic       out_low_i,
   input  logic       uv_i,
   input  logic       oc_lvl1_i,
   input  logic       oc_lvl2_i,
   output logic       hs_off_o,
   output logic       ls_on_o,
   output logic       ls_off_o,
   output logic       bleed_en_o,
   output logic [1:0] fault_code_o
);

   import fg_pkg::*;

   logic      active;
   logic      pre_arm;
   logic      oc_trip;
   fg_state_e state;

   assign active  = supply_ok_i & enable_i;
   assign pre_arm = supply_ok_i & ~enable_i;

   fg_oc_filter #(.OC_CYCLES(OC_CYCLES)) u_oc_filter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (~active),
      .tick_i  (cycle_tick_i),
      .lvl1_i  (oc_lvl1_i),
      .trip_o  (oc_trip)
   );

   fg_fault_fsm u_fault_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (active),
      .ov_i      (ov_hi_i),
      .out_low_i (out_low_i),
      .uv_i      (uv_i),
      .ss_done_i (ss_done_i),
      .oc2_i     (oc_lvl2_i),
      .oc_trip_i (oc_trip),
      .state_o   (state)
   );

   fg_gate_map u_gate_map (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .state_i    (state),
      .pre_arm_i  (pre_arm),
      .ov_i       (ov_hi_i),
      .hs_off_o   (hs_off_o),
      .ls_on_o    (ls_on_o),
      .ls_off_o   (ls_off_o),
      .bleed_en_o (bleed_en_o),
      .code_o     (fault_code_o)
   );

endmodule

// File: tb/conv_fault_guard_bench.sv
`timescale 1ns/1ps
module conv_fault_guard_bench;

   localparam int OCN = 4;
   // {hs_off, ls_on, ls_off, bleed, code[1:0]}
   localparam logic [5:0] E_NONE = 6'b000000;
   localparam logic [5:0] E_OVC  = 6'b110001;
   localparam logic [5:0] E_OVB  = 6'b101101;
   localparam logic [5:0] E_UV   = 6'b101010;
   localparam logic [5:0] E_OC   = 6'b101011;
   localparam logic [5:0] E_PRE  = 6'b010000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, en = 0, sup = 0, ss = 0, ov = 0, olow = 0, uv = 0, oc1 = 0, oc2 = 0;
   logic hs_off, ls_on, ls_off, bleed;
   logic [1:0] code;
   int checks = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   conv_fault_guard #(.OC_CYCLES(OCN)) u_conv_fault_guard (
      .clk_i(clk), .rst_ni(rst_n), .cycle_tick_i(tick), .enable_i(en),
      .supply_ok_i(sup), .ss_done_i(ss), .ov_hi_i(ov), .out_low_i(olow),
      .uv_i(uv), .oc_lvl1_i(oc1), .oc_lvl2_i(oc2),
      .hs_off_o(hs_off), .ls_on_o(ls_on), .ls_off_o(ls_off),
      .bleed_en_o(bleed), .fault_code_o(code));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [5:0] exp);
      logic [5:0] got;
      got = {hs_off, ls_on, ls_off, bleed, code};
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic flags_off();
      tick = 0; ss = 0; ov = 0; olow = 0; uv = 0; oc1 = 0; oc2 = 0;
   endtask

   task automatic reclear();
      flags_off();
      sup = 1; en = 0;
      step();
      en = 1;
      step();
   endtask

   task automatic oc_tick(input logic lvl);
      oc1 = lvl; tick = 1;
      step();
      tick = 0;
      step();   // tickless clock with level held
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: got hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      chk("R1 reset", E_NONE);
      ov = 1; uv = 1; ss = 1; oc2 = 1;
      step();
      chk("R1 supply low ignores flags", E_NONE);
      flags_off();
      sup = 1; en = 1;
      step();
      chk("R1 enabled idle", E_NONE);

      // R2 / R3 / R8 / R9
      ov = 1; ss = 0;
      step();
      chk("R2 ov during soft-start", E_OVC);
      ov = 0;
      step();
      chk("R9 ov kept after flag drops", E_OVC);
      olow = 1;
      step();
      chk("R3 bleed phase", E_OVB);
      olow = 0;
      step();
      chk("R3 bleed sticky", E_OVB);
      uv = 1; ss = 1; oc2 = 1;
      step();
      chk("R8 first code kept", E_OVB);
      flags_off();
      en = 0;
      step();
      chk("R9 enable toggle clears", E_NONE);
      en = 1;
      step();
      chk("R9 re-enable stays clear", E_NONE);

      // R4
      uv = 1; ss = 0;
      repeat (3) step();
      chk("R4 uv ignored before soft-start", E_NONE);
      ss = 1;
      step();
      chk("R4 uv latch", E_UV);
      uv = 0;
      step();
      chk("R9 uv held", E_UV);
      sup = 0;
      step();
      chk("R9 supply loss clears", E_NONE);

      // R7
      reclear();
      oc2 = 1; tick = 0;
      step();
      oc2 = 0;
      chk("R7 oc2 immediate", E_OC);

      // R5 run lengths
      for (int len = 1; len <= 6; len++) begin
         reclear();
         for (int i = 0; i < len; i++) oc_tick(1'b1);
         oc1 = 0;
         step();
         chk($sformatf("R5 run of %0d ticks", len), (len >= OCN) ? E_OC : E_NONE);
      end

      // R6 break in the run
      for (int k = 1; k < OCN; k++) begin
         reclear();
         for (int i = 0; i < k; i++) oc_tick(1'b1);
         oc_tick(1'b0);
         for (int i = 0; i < OCN - 1; i++) oc_tick(1'b1);
         oc1 = 0;
         step();
         chk($sformatf("R6 break after %0d", k), E_NONE);
         oc_tick(1'b1);
         chk($sformatf("R6 full run after break %0d", k), E_OC);
      end

      // R8 priority sweep over {ov, oc2, uv, ss}
      for (int m = 0; m < 16; m++) begin
         logic [5:0] e;
         reclear();
         ov = m[3]; oc2 = m[2]; uv = m[1]; ss = m[0];
         step();
         e = m[3] ? E_OVC : (m[2] ? E_OC : ((m[1] && m[0]) ? E_UV : E_NONE));
         chk($sformatf("R8 combo %0d", m), e);
         flags_off();
      end

      // R10
      reclear();
      en = 0; ov = 1;
      step();
      chk("R10 pre-enable clamp", E_PRE);
      ov = 0;
      step();
      chk("R10 pre-enable release", E_NONE);
      sup = 0; ov = 1;
      step();
      chk("R10 no clamp without supply", E_NONE);
      sup = 1; en = 1;
      step();
      chk("R10 enabled uses ov latch", E_OVC);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule